// File: doc/BRIEF.md
# Multi-Domain Clock Frequency Fault Monitor

This block keeps watch over a set of clocks from one reference clock. For every monitored domain, a small Gray-coded counter runs on the monitored clock. That count is carried into the reference domain. There the edges seen during a fixed window of reference cycles are added up, and the total is judged against a low and a high count threshold that can be programmed for each domain. Four kinds of fault are recorded in a sticky status word for each domain: no edge at all, too few edges, too many edges, and a total that ran past the counter's range.

Domain slots live in a sparse index space. A parameter mask chooses which slots are built. A slot that is not built reads as zero and ignores writes. Each domain also holds an access mask, indexed by the requester's privilege level, which guards writes to that domain's thresholds and status. The summary fault bits of all built domains are ORed into one master fault output, which can also be read at a global address.

Top module: `clk_freq_guard`

## Requirements
- R1: After reset, every built domain reads high threshold all ones, low threshold zero, status zero and access mask all ones, and the master fault is 0.
- R2: At the end of each window of WIN_CYC reference cycles, a domain whose edge total is strictly below its low threshold sets status bit 1. A total equal to the threshold sets nothing. The first window after reset is discarded.
- R3: A window total strictly above the high threshold sets status bit 2. A total equal to the threshold sets nothing.
- R4: A window with no rising edge of the monitored clock sets status bit 0.
- R5: When the window total would exceed 2^CNT_W-1, the total holds at that value and status bit 3 is set. This happens whether or not the high threshold is also crossed.
- R6: Status bit 4 reads as the OR of bits 0 to 3 of the same domain. It is read-only, and it drops when those bits are cleared.
- R7: Status bits 0 to 3 stay set until a 1 is written to that bit position. Writing 0 leaves them unchanged. A fault found in the same cycle as a clear wins.
- R8: The fault_master output, and bit 0 of any read with the global address bit set, equal the OR of the summary bits of all domains.
- R9: A slot not selected by SLOT_EN reads all zeros at every register index, and writes to it have no effect.
- R10: A write to a domain's thresholds or status takes effect only when bit reg_lvl of that domain's access mask is 1. The access mask itself is written only when reg_lvl is all ones. Reads are never blocked.
- R11: The address is {global bit, slot, index}, with index 0 the high threshold, 1 the low threshold, 2 the status and 3 the access mask. Read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; sets the window timing and runs the register interface |
| rst | input | 1 | Synchronous active-high reset in the reference domain |
| mon_clk | input | NUM_DOM | One monitored clock per built slot, in ascending slot order |
| reg_addr | input | SLOT_W+3 | Register address {global, slot, index} |
| reg_we | input | 1 | Write strobe for one reference cycle |
| reg_wdata | input | DATA_W | Write data |
| reg_lvl | input | LVL_W | Privilege level of the requester |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| fault_master | output | 1 | OR of every domain's summary fault |

## Verification
The bench uses the default parameters. These are four slots, with slot 2 left out so that a hole sits between built slots, and three monitored clocks. The window is 64 cycles and the counts are 8 bits wide, so the overflow limit is 255. Every monitored clock period divides the 640-unit window exactly. Each window therefore holds an exact edge total: 16, 32, 160, or 320 for the fastest clock. This exactness allows the bench to set a threshold equal to the total and one step away from it. The 320-edge clock drives the saturation path with the high threshold both crossed and uncrossed, and stopping a clock exercises the stuck-clock case.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

    // Register index inside one domain slot.
    typedef enum logic [1:0] {
        SEL_HI   = 2'd0,
        SEL_LO   = 2'd1,
        SEL_STAT = 2'd2,
        SEL_MASK = 2'd3
    } reg_sel_e;

    // Sticky fault word; same layout for every domain (dc is bit 0).
    typedef struct packed {
        logic ovf;
        logic hi;
        logic lo;
        logic dc;
    } fault_t;

    localparam int FAULT_W = $bits(fault_t);

    // Position of a built slot among the monitored clock inputs.
    function automatic int dom_of_slot(input logic [31:0] en, input int slot);
        int n;
        n = 0;
        for (int i = 0; i < 32; i++) begin
            if (i < slot && en[i]) n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/cfm_edge_counter.sv
module cfm_edge_counter #(
    parameter int G_W = 4
) (
    input  logic           mon_clk,
    input  logic           clk,
    input  logic           rst,
    output logic [G_W-1:0] cnt_bin
);

    // Monitored-domain counter; only differences are used, so its
    // start value is irrelevant and it needs no reset (the clock may be dead).
    logic [G_W-1:0] m_bin;
    logic [G_W-1:0] m_gray;
    logic [G_W-1:0] m_next;

    assign m_next = m_bin + 1'b1;

    always_ff @(posedge mon_clk) begin
        m_bin  <= m_next;
        m_gray <= m_next ^ (m_next >> 1);
    end

    // Two-stage capture into the reference domain.
    logic [G_W-1:0] s1_gray;
    logic [G_W-1:0] s2_gray;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_gray <= '0;
            s2_gray <= '0;
        end else begin
            s1_gray <= m_gray;
            s2_gray <= s1_gray;
        end
    end

    always_comb begin
        cnt_bin[G_W-1] = s2_gray[G_W-1];
        for (int i = G_W - 2; i >= 0; i--) begin
            cnt_bin[i] = cnt_bin[i+1] ^ s2_gray[i];
        end
    end

endmodule

// File: rtl/cfm_domain.sv
module cfm_domain
    import cfm_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int G_W    = 4,
    parameter int LVL_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mon_clk,
    input  logic              win_tick,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LVL_W-1:0]  wr_lvl,
    output logic [DATA_W-1:0] rd_data,
    output logic              fault_sum
);

    localparam int MASK_W = 2 ** LVL_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [G_W-1:0]    cur_bin;
    logic [G_W-1:0]    prev_bin;
    logic [G_W-1:0]    step;
    logic [CNT_W:0]    acc_sum;
    logic [CNT_W-1:0]  acc;
    logic              sat;
    logic              armed;
    logic [CNT_W-1:0]  hi_thr;
    logic [CNT_W-1:0]  lo_thr;
    logic [MASK_W-1:0] acc_mask;
    fault_t            st;
    fault_t            verdict;
    fault_t            clr;
    logic              judge;
    logic              priv_ok;
    logic              top_lvl;

    cfm_edge_counter #(.G_W(G_W)) u_edge (
        .mon_clk (mon_clk),
        .clk     (clk),
        .rst     (rst),
        .cnt_bin (cur_bin)
    );

    // ---------------- window measurement ----------------
    always_comb begin
        step        = cur_bin - prev_bin;
        acc_sum     = {1'b0, acc} + (CNT_W + 1)'(step);
        verdict.dc  = (acc == '0);
        verdict.lo  = (acc < lo_thr);
        verdict.hi  = (acc > hi_thr);
        verdict.ovf = sat;
        judge       = win_tick && armed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_bin <= '0;
            acc      <= '0;
            sat      <= 1'b0;
            armed    <= 1'b0;
        end else begin
            prev_bin <= cur_bin;
            if (win_tick) begin
                // this cycle's edges open the next window
                acc   <= CNT_W'(step);
                sat   <= 1'b0;
                armed <= 1'b1;
            end else if (sat || acc_sum[CNT_W]) begin
                acc <= CNT_MAX;
                sat <= 1'b1;
            end else begin
                acc <= acc_sum[CNT_W-1:0];
            end
        end
    end

    // ---------------- registers ----------------
    always_comb begin
        priv_ok = acc_mask[wr_lvl];
        top_lvl = (wr_lvl == {LVL_W{1'b1}});
        clr     = (wr_en && sel == SEL_STAT && priv_ok) ? fault_t'(wr_data[FAULT_W-1:0]) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_thr   <= CNT_MAX;
            lo_thr   <= '0;
            acc_mask <= '1;
            st       <= '0;
        end else begin
            if (wr_en && priv_ok && sel == SEL_HI) hi_thr <= wr_data[CNT_W-1:0];
            if (wr_en && priv_ok && sel == SEL_LO) lo_thr <= wr_data[CNT_W-1:0];
            if (wr_en && top_lvl && sel == SEL_MASK) acc_mask <= wr_data[MASK_W-1:0];
            st <= (st & ~clr) | (judge ? verdict : fault_t'('0));
        end
    end

    assign fault_sum = |st;

    always_comb begin
        unique case (sel)
            SEL_HI:   rd_data = DATA_W'(hi_thr);
            SEL_LO:   rd_data = DATA_W'(lo_thr);
            SEL_STAT: rd_data = DATA_W'({fault_sum, st});
            SEL_MASK: rd_data = DATA_W'(acc_mask);
            default:  rd_data = '0;
        endcase
    end

    // ---------------- assertions ----------------
    logic [FAULT_W-1:0] st_v;
    logic [FAULT_W-1:0] clr_v;
    assign st_v  = st;
    assign clr_v = clr;

    // R7: a set bit survives every cycle without a clear on its position
    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (($past(st_v) & ~$past(clr_v) & ~st_v) == '0));

    // R2: a total below the low threshold at a judged window is latched
    assert_low_flag_R2: assert property (@(posedge clk) disable iff (rst)
        (judge && acc < lo_thr) |=> st.lo);

    // R3: a total above the high threshold at a judged window is latched
    assert_high_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (judge && acc > hi_thr) |=> st.hi);

    // R4: an empty window is latched as a stuck clock
    assert_dc_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (judge && acc == '0) |=> st.dc);

    // R5: a saturated window holds the total at its ceiling
    assert_sat_ceiling_R5: assert property (@(posedge clk) disable iff (rst)
        sat |-> (acc == CNT_MAX));

    // R10: a write without the privilege bit leaves the thresholds alone
    assert_priv_block_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !priv_ok) |=> ($stable(hi_thr) && $stable(lo_thr)));

endmodule

// File: rtl/clk_freq_guard.sv
module clk_freq_guard
    import cfm_pkg::*;
#(
    parameter int                 NUM_SLOTS = 4,
    parameter logic [NUM_SLOTS-1:0] SLOT_EN = 4'b1011,
    parameter int                 CNT_W     = 8,
    parameter int                 G_W       = 4,
    parameter int                 WIN_CYC   = 64,
    parameter int                 LVL_W     = 2,
    localparam int NUM_DOM = $countones(SLOT_EN),
    localparam int SLOT_W  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int ADDR_W  = SLOT_W + 3,
    localparam int DW0     = (CNT_W > FAULT_W + 1) ? CNT_W : FAULT_W + 1,
    localparam int DATA_W  = (DW0 > 2 ** LVL_W) ? DW0 : 2 ** LVL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_DOM-1:0] mon_clk,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [LVL_W-1:0]  reg_lvl,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              fault_master
);

    localparam int SLOT_SPACE = 2 ** SLOT_W;
    localparam int WIN_W      = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;

    // ---------------- window timer ----------------
    logic [WIN_W-1:0] win_cnt;
    logic             win_tick;

    assign win_tick = (win_cnt == WIN_W'(WIN_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst)           win_cnt <= '0;
        else if (win_tick) win_cnt <= '0;
        else               win_cnt <= win_cnt + 1'b1;
    end

    // ---------------- address decode ----------------
    logic              addr_glob;
    logic [SLOT_W-1:0] addr_slot;
    reg_sel_e          addr_sel;

    assign addr_glob = reg_addr[ADDR_W-1];
    assign addr_slot = reg_addr[ADDR_W-2:2];
    assign addr_sel  = reg_sel_e'(reg_addr[1:0]);

    logic [DATA_W-1:0]     slot_rd   [SLOT_SPACE];
    logic [SLOT_SPACE-1:0] slot_sum;
    logic [SLOT_SPACE-1:0] slot_impl;

    for (genvar s = 0; s < SLOT_SPACE; s++) begin : g_slot
        if (s >= NUM_SLOTS) begin : g_void
            assign slot_rd[s]   = '0;
            assign slot_sum[s]  = 1'b0;
            assign slot_impl[s] = 1'b0;
        end else if (SLOT_EN[s]) begin : g_dom
            localparam int DI = dom_of_slot(32'(SLOT_EN), s);
            logic wr_hit;
            assign wr_hit       = reg_we && !addr_glob && (addr_slot == SLOT_W'(s));
            assign slot_impl[s] = 1'b1;
            cfm_domain #(
                .CNT_W  (CNT_W),
                .G_W    (G_W),
                .LVL_W  (LVL_W),
                .DATA_W (DATA_W)
            ) u_dom (
                .clk       (clk),
                .rst       (rst),
                .mon_clk   (mon_clk[DI]),
                .win_tick  (win_tick),
                .wr_en     (wr_hit),
                .sel       (addr_sel),
                .wr_data   (reg_wdata),
                .wr_lvl    (reg_lvl),
                .rd_data   (slot_rd[s]),
                .fault_sum (slot_sum[s])
            );
        end else begin : g_hole
            assign slot_rd[s]   = '0;
            assign slot_sum[s]  = 1'b0;
            assign slot_impl[s] = 1'b0;
        end
    end

    assign fault_master = |slot_sum;

    always_comb begin
        if (addr_glob) reg_rdata = DATA_W'(fault_master);
        else           reg_rdata = slot_rd[addr_slot];
    end

    // R9: a hole slot never returns data
    assert_hole_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (!addr_glob && !slot_impl[addr_slot]) |-> (reg_rdata == '0));

    // R2: the judging tick repeats exactly every WIN_CYC cycles
    assert_tick_period_R2: assert property (@(posedge clk) disable iff (rst)
        win_tick |=> (win_cnt == '0));

endmodule

// File: tb/clk_freq_guard_tb_top.sv
module clk_freq_guard_tb_top;

    localparam int WIN   = 64;
    localparam int GBIT  = 16;

    logic       clk;
    logic       rst;
    logic [2:0] mclk;
    logic [4:0] reg_addr;
    logic       reg_we;
    logic [7:0] reg_wdata;
    logic [1:0] reg_lvl;
    logic [7:0] reg_rdata;
    logic       fault_master;

    int per [3];

    clk_freq_guard dut_i (
        .clk          (clk),
        .rst          (rst),
        .mon_clk      (mclk),
        .reg_addr     (reg_addr),
        .reg_we       (reg_we),
        .reg_wdata    (reg_wdata),
        .reg_lvl      (reg_lvl),
        .reg_rdata    (reg_rdata),
        .fault_master (fault_master)
    );

    // 100 MHz reference: 10-unit period, rising edges at odd times
    initial begin
        clk = 1'b0;
        forever #5 clk = ~clk;
    end

    // Monitored clocks rise on multiples of their even period, never
    // on a reference edge; period 0 holds the clock low.
    initial begin
        per[0] = 40;
        per[1] = 4;
        per[2] = 20;
        mclk   = '0;
        forever begin
            #1;
            for (int d = 0; d < 3; d++) begin
                mclk[d] = (per[d] != 0) && (($time % longint'(per[d])) < longint'(per[d] / 2));
            end
        end
    end

    typedef struct {
        bit    use_port;
        int    addr;
        int    exp;
        string tag;
    } item_t;

    item_t exp_q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;

    // monitor: pops expectations and compares away from the rising edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            item_t it;
            int    act;
            it  = exp_q.pop_front();
            act = it.use_port ? int'(fault_master) : int'(reg_rdata);
            n_vec++;
            if (act != it.exp) begin
                n_bad++;
                $display("FAIL %s addr=%0h actual=%0h expected=%0h", it.tag, it.addr, act, it.exp);
            end
        end
    end

    function automatic int ra(input int slot, input int sel);
        return slot * 4 + sel;
    endfunction

    task automatic expect_reg(input int a, input int e, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        reg_addr    = 5'(a);
        it.use_port = 1'b0;
        it.addr     = a;
        it.exp      = e;
        it.tag      = tag;
        exp_q.push_back(it);
        wait (exp_q.size() == 0);
    endtask

    task automatic expect_master(input int e, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        it.use_port = 1'b1;
        it.addr     = 0;
        it.exp      = e;
        it.tag      = tag;
        exp_q.push_back(it);
        wait (exp_q.size() == 0);
    endtask

    task automatic wr(input int a, input int d, input int lvl);
        @(posedge clk);
        #1;
        reg_addr  = 5'(a);
        reg_wdata = 8'(d);
        reg_lvl   = 2'(lvl);
        reg_we    = 1'b1;
        @(posedge clk);
        #1;
        reg_we    = 1'b0;
    endtask

    task automatic wait_win(input int n);
        repeat (n * WIN) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            finish_run();
        end
    end

    int slots [3] = '{0, 1, 3};

    initial begin
        rst       = 1'b1;
        reg_we    = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
        reg_lvl   = 2'd3;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 / R11: reset contents at the mapped indices
        foreach (slots[k]) begin
            expect_reg(ra(slots[k], 0), 8'hFF, "R1 high threshold reset");
            expect_reg(ra(slots[k], 1), 8'h00, "R1 low threshold reset");
            expect_reg(ra(slots[k], 2), 8'h00, "R1 status reset");
            expect_reg(ra(slots[k], 3), 8'h0F, "R11 mask reset");
        end
        for (int i = 0; i < 4; i++) expect_reg(ra(2, i), 0, "R9 hole reads zero");
        expect_master(0, "R1 master reset");

        // program in-range thresholds: counts 16, 160, 32
        wr(ra(0, 1), 10, 3);  wr(ra(0, 0), 20, 3);
        wr(ra(1, 1), 150, 3); wr(ra(1, 0), 170, 3);
        wr(ra(3, 1), 28, 3);  wr(ra(3, 0), 36, 3);
        expect_reg(ra(0, 0), 20, "R11 high threshold write");
        expect_reg(ra(1, 1), 150, "R11 low threshold write");
        wait_win(3);
        foreach (slots[k]) wr(ra(slots[k], 2), 8'h0F, 3);
        wait_win(2);
        foreach (slots[k]) expect_reg(ra(slots[k], 2), 0, "R2 R3 in-range no fault");
        expect_master(0, "R8 master quiet");

        // R2 low fault on slot 0 (16 < 17)
        wr(ra(0, 1), 17, 3);
        wait_win(2);
        expect_reg(ra(0, 2), 8'h12, "R2 low fault with R6 summary");
        expect_reg(ra(3, 2), 8'h00, "R2 other domain unaffected");
        expect_master(1, "R8 master raised");
        expect_reg(GBIT, 1, "R8 global read");

        // R7 sticky and write-one-to-clear
        wr(ra(0, 1), 10, 3);
        wait_win(2);
        expect_reg(ra(0, 2), 8'h12, "R7 sticky after cause gone");
        wr(ra(0, 2), 8'h00, 3);
        expect_reg(ra(0, 2), 8'h12, "R7 write zero ignored");
        wr(ra(0, 2), 8'h02, 3);
        expect_reg(ra(0, 2), 8'h00, "R7 write one clears");
        expect_master(0, "R8 master dropped");
        expect_reg(GBIT, 0, "R8 global read low");

        // R2 / R3 equality boundary on slot 3 (count 32)
        wr(ra(3, 1), 32, 3); wr(ra(3, 0), 32, 3);
        wait_win(2);
        expect_reg(ra(3, 2), 8'h00, "R2 R3 equal count no fault");
        wr(ra(3, 1), 33, 3);
        wait_win(2);
        expect_reg(ra(3, 2), 8'h12, "R2 one below low");
        wr(ra(3, 1), 32, 3);
        wait_win(2);
        wr(ra(3, 2), 8'hFF, 3);
        expect_reg(ra(3, 2), 8'h00, "R6 summary read-only clears");
        wr(ra(3, 0), 31, 3);
        wait_win(2);
        expect_reg(ra(3, 2), 8'h14, "R3 one above high");
        wr(ra(3, 1), 28, 3); wr(ra(3, 0), 36, 3);
        wait_win(2);
        wr(ra(3, 2), 8'h0F, 3);
        expect_reg(ra(3, 2), 8'h00, "R3 recovered");

        // R4 stuck clock on slot 1
        per[1] = 0;
        wait_win(2);
        wr(ra(1, 2), 8'h0F, 3);
        wait_win(2);
        expect_reg(ra(1, 2), 8'h13, "R4 stuck clock with low");
        expect_master(1, "R8 master on stuck clock");

        // R5 overflow: 320 edges saturate at 255
        per[1] = 2;
        wait_win(2);
        wr(ra(1, 2), 8'h0F, 3);
        wait_win(2);
        expect_reg(ra(1, 2), 8'h1C, "R5 overflow with high");
        wr(ra(1, 0), 8'hFF, 3);
        wait_win(1);
        wr(ra(1, 2), 8'h0F, 3);
        wait_win(2);
        expect_reg(ra(1, 2), 8'h18, "R5 overflow alone");
        per[1] = 4;
        wr(ra(1, 0), 170, 3);
        wait_win(2);
        wr(ra(1, 2), 8'h0F, 3);
        wait_win(1);
        expect_reg(ra(1, 2), 8'h00, "R5 recovered");

        // R10 privilege mask on slot 0
        wr(ra(0, 3), 8'h01, 3);
        expect_reg(ra(0, 3), 8'h01, "R10 mask written at top level");
        wr(ra(0, 0), 8'h55, 2);
        expect_reg(ra(0, 0), 20, "R10 blocked high write");
        wr(ra(0, 1), 8'h05, 1);
        expect_reg(ra(0, 1), 10, "R10 blocked low write");
        wr(ra(0, 0), 8'h55, 0);
        expect_reg(ra(0, 0), 8'h55, "R10 allowed write");
        wr(ra(0, 3), 8'h0F, 1);
        expect_reg(ra(0, 3), 8'h01, "R10 mask write below top level");

        // R9 writes to the hole slot
        for (int i = 0; i < 4; i++) wr(ra(2, i), 8'hAA, 3);
        for (int i = 0; i < 4; i++) expect_reg(ra(2, i), 0, "R9 hole ignores writes");

        done = 1;
        finish_run();
    end

endmodule